// File: doc/BRIEF.md
# Card Clock-Rate Ratio and Waiting-Time Calculator

This block converts the clock-rate index and the baud-adjustment index negotiated during a smart-card answer-to-reset into the number of card clock cycles per elementary time unit, which a receiver uses as its bit period. From the same adjustment index and the waiting-integer byte it also produces the character waiting time, in elementary time units, that a timer loads.

A caller presents the two 4-bit indices and the 8-bit waiting integer together with a one-cycle `start`. The block latches them and looks up the clock-rate factor F and the adjustment factor D from fixed tables. It then either divides F by D with a sequential restoring divider or multiplies F by D with a sequential shift-add multiplier. At the same time a second shift-add multiplier forms 960·D·WI. When both results are ready, the block checks the ratio, updates its outputs and raises `done` for one cycle. A rejected ratio leaves the previous ratio in place and drops `ratio_ok`. The waiting time is always refreshed.

The controller has four states. IDLE waits for work. FETCH registers the table lookups and launches the arithmetic units. RUN waits until every launched unit has finished. DONE commits the results. The transitions are: IDLE→FETCH on `start`, FETCH→RUN always, RUN→DONE once no unit is pending, DONE→FETCH on `start` (back-to-back work), and DONE→IDLE otherwise.

Top module: `iso_rate_calc`

## Requirements
- R1: After reset, `ratio` is 372, `ratio_ok` is 1, `wtime` is 9600 and `done` is 0. These are the values for clock-rate index 1, adjustment index 1 and waiting integer 10.
- R2: When the adjustment index is below 8 and both table entries are nonzero, the candidate ratio is F divided by D, truncated. Examples: index pair (6,5) gives 1860/16 = 116, and (4,4) gives 1116/8 = 139.
- R3: When the adjustment index is 8 or above and both table entries are nonzero, the candidate ratio is F multiplied by D. Example: (1,10) gives 372·2 = 744.
- R4: The F table, indexed 0..15, is 0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0. The D table is 0,1,2,4,8,16,0,0,0,0,2,4,8,16,32,64. A zero entry in either table makes the pair invalid: `ratio_ok` goes to 0 and `ratio` keeps its previous value.
- R5: A candidate ratio that is 0 or not below 1024 is rejected: `ratio_ok` goes to 0 and `ratio` keeps its previous value. An accepted candidate sets `ratio` and sets `ratio_ok` to 1.
- R6: `wtime` becomes 960·D·WI on every completed request, whether the ratio is accepted or not. A zero D entry gives 0.
- R7: `done` is high for exactly one cycle per request. `ratio`, `ratio_ok` and `wtime` change only in a cycle where `done` is high.
- R8: A `start` pulse that arrives while a request is in FETCH or RUN is ignored. The result belongs to the first request, and no extra `done` follows.
- R9: A `start` pulse in the cycle where `done` is high is accepted as a new request, and its result follows with its own `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| fi_idx | input | 4 | Clock-rate table index |
| di_idx | input | 4 | Adjustment-factor table index |
| wi | input | 8 | Waiting integer |
| ratio | output | 10 | Clock cycles per elementary time unit |
| ratio_ok | output | 1 | Last candidate ratio was accepted |
| wtime | output | 24 | Waiting time in elementary time units |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two things can fall on the same cycle here: committing one result and accepting the next request, because `start` is honoured in DONE. The bench provokes this by raising `start` on the very cycle in which it sees `done`. It then requires the first request's values at that `done` and the second request's values at the following `done`. It also drives a second `start` while the dividers and multipliers are busy, and judges that the outcome belongs to the first request alone and that no stray `done` appears.

// File: rtl/iso_rate_pkg.sv
package iso_rate_pkg;

    localparam int IDX_W   = 4;
    localparam int WI_W    = 8;
    localparam int F_W     = 12;
    localparam int D_W     = 7;
    localparam int RATIO_W = 10;
    localparam int BASE_WT = 960;
    localparam int K_W     = 16;
    localparam int WT_W    = K_W + WI_W;
    localparam int CAND_W  = F_W + D_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN,
        ST_DONE
    } calc_state_t;

    function automatic logic [F_W-1:0] f_lookup(input logic [IDX_W-1:0] idx);
        logic [F_W-1:0] v;
        unique case (idx)
            4'd1:    v = 12'd372;
            4'd2:    v = 12'd558;
            4'd3:    v = 12'd744;
            4'd4:    v = 12'd1116;
            4'd5:    v = 12'd1488;
            4'd6:    v = 12'd1860;
            4'd9:    v = 12'd512;
            4'd10:   v = 12'd768;
            4'd11:   v = 12'd1024;
            4'd12:   v = 12'd1536;
            4'd13:   v = 12'd2048;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [D_W-1:0] d_lookup(input logic [IDX_W-1:0] idx);
        logic [D_W-1:0] v;
        unique case (idx)
            4'd1:    v = 7'd1;
            4'd2:    v = 7'd2;
            4'd3:    v = 7'd4;
            4'd4:    v = 7'd8;
            4'd5:    v = 7'd16;
            4'd10:   v = 7'd2;
            4'd11:   v = 7'd4;
            4'd12:   v = 7'd8;
            4'd13:   v = 7'd16;
            4'd14:   v = 7'd32;
            4'd15:   v = 7'd64;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/seq_mult.sv
module seq_mult #(
    parameter int AW = 12,
    parameter int BW = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [AW-1:0]       a,
    input  logic [BW-1:0]       b,
    output logic [AW+BW-1:0]    prod,
    output logic                fin
);
    localparam int PW = AW + BW;
    localparam int CW = $clog2(BW + 1);

    logic [PW-1:0] mcand;
    logic [BW-1:0] mplier;
    logic [PW-1:0] acc;
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else if (go) begin
            mcand  <= PW'(a);
            mplier <= b;
            acc    <= '0;
            cnt    <= CW'(BW);
            active <= 1'b1;
            fin    <= 1'b0;
        end else if (active) begin
            if (mplier[0]) begin
                acc <= acc + mcand;
            end
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                active <= 1'b0;
                fin    <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign prod = acc;

endmodule

// File: rtl/seq_div.sv
module seq_div #(
    parameter int NW = 12,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          fin
);
    localparam int CW = $clog2(NW + 1);

    logic [DW:0]   rem;
    logic [NW-1:0] q_sh;
    logic [DW-1:0] den_l;
    logic [NW-1:0] num_l;
    logic [CW-1:0] cnt;
    logic          active;
    logic [DW:0]   trial;
    logic [DW:0]   diff;

    assign trial = {rem[DW-1:0], q_sh[NW-1]};
    assign diff  = trial - {1'b0, den_l};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem    <= '0;
            q_sh   <= '0;
            den_l  <= '0;
            num_l  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else if (go) begin
            rem    <= '0;
            q_sh   <= num;
            num_l  <= num;
            den_l  <= den;
            cnt    <= CW'(NW);
            active <= 1'b1;
            fin    <= 1'b0;
        end else if (active) begin
            if (trial >= {1'b0, den_l}) begin
                rem  <= diff;
                q_sh <= {q_sh[NW-2:0], 1'b1};
            end else begin
                rem  <= trial;
                q_sh <= {q_sh[NW-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                active <= 1'b0;
                fin    <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign quo = q_sh;

    // R2
    div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((NW+DW+1)'(q_sh) * (NW+DW+1)'(den_l) + (NW+DW+1)'(rem)
                 == (NW+DW+1)'(num_l)) && (rem < {1'b0, den_l}));

    // R4
    div_den_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (den != '0));

endmodule

// File: rtl/iso_rate_calc.sv
module iso_rate_calc
    import iso_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   fi_idx,
    input  logic [IDX_W-1:0]   di_idx,
    input  logic [WI_W-1:0]    wi,
    output logic [RATIO_W-1:0] ratio,
    output logic               ratio_ok,
    output logic [WT_W-1:0]    wtime,
    output logic               done
);
    localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(372);
    localparam logic [WT_W-1:0]    RST_WT    = WT_W'(BASE_WT * 10);

    calc_state_t state, next;

    logic [IDX_W-1:0] fi_l, di_l;
    logic [WI_W-1:0]  wi_l;
    logic [F_W-1:0]   f_val;
    logic [D_W-1:0]   d_val;
    logic             pair_bad, bad_l;
    logic             rat_pend, wt_pend;
    logic             accept;

    logic             div_go, mul_go, wt_go;
    logic [F_W-1:0]   div_quo;
    logic             div_fin;
    logic [CAND_W-1:0] mul_prod;
    logic             mul_fin;
    logic [WT_W-1:0]  wt_prod;
    logic             wt_fin;
    logic [K_W-1:0]   wt_scale;
    logic [CAND_W-1:0] cand;
    logic             cand_fits;

    assign f_val    = f_lookup(fi_l);
    assign d_val    = d_lookup(di_l);
    assign pair_bad = (f_val == '0) || (d_val == '0);
    assign accept   = start && ((state == ST_IDLE) || (state == ST_DONE));

    assign div_go   = (state == ST_FETCH) && !pair_bad && !di_l[IDX_W-1];
    assign mul_go   = (state == ST_FETCH) && !pair_bad &&  di_l[IDX_W-1];
    assign wt_go    = (state == ST_FETCH);
    assign wt_scale = K_W'(BASE_WT) * K_W'(d_val);

    seq_div #(.NW(F_W), .DW(D_W)) i_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(f_val), .den(d_val), .quo(div_quo), .fin(div_fin)
    );

    seq_mult #(.AW(F_W), .BW(D_W)) i_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .a(f_val), .b(d_val), .prod(mul_prod), .fin(mul_fin)
    );

    seq_mult #(.AW(K_W), .BW(WI_W)) i_wt (
        .clk(clk), .rst_n(rst_n), .go(wt_go),
        .a(wt_scale), .b(wi_l), .prod(wt_prod), .fin(wt_fin)
    );

    assign cand      = di_l[IDX_W-1] ? mul_prod : CAND_W'(div_quo);
    assign cand_fits = !bad_l && (cand != '0) && (cand[CAND_W-1:RATIO_W] == '0);

    // next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:  if (start) next = ST_FETCH;
            ST_FETCH: next = ST_RUN;
            ST_RUN:   if (!rat_pend && !wt_pend) next = ST_DONE;
            ST_DONE:  next = start ? ST_FETCH : ST_IDLE;
            default:  next = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // request capture and unit tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi_l     <= IDX_W'(1);
            di_l     <= IDX_W'(1);
            wi_l     <= WI_W'(10);
            bad_l    <= 1'b0;
            rat_pend <= 1'b0;
            wt_pend  <= 1'b0;
        end else begin
            if (accept) begin
                fi_l <= fi_idx;
                di_l <= di_idx;
                wi_l <= wi;
            end
            if (state == ST_FETCH) begin
                bad_l    <= pair_bad;
                rat_pend <= !pair_bad;
                wt_pend  <= 1'b1;
            end else begin
                if (div_fin || mul_fin) rat_pend <= 1'b0;
                if (wt_fin)             wt_pend  <= 1'b0;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio    <= RST_RATIO;
            ratio_ok <= 1'b1;
            wtime    <= RST_WT;
            done     <= 1'b0;
        end else begin
            done <= (state == ST_RUN) && (next == ST_DONE);
            if ((state == ST_RUN) && (next == ST_DONE)) begin
                wtime <= wt_prod;
                if (cand_fits) begin
                    ratio    <= cand[RATIO_W-1:0];
                    ratio_ok <= 1'b1;
                end else begin
                    ratio_ok <= 1'b0;
                end
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ratio) && $stable(ratio_ok) && $stable(wtime)));

    // R5
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok |-> (ratio != '0));

    // R6
    wtime_formula_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(wtime) == 32'(BASE_WT) * 32'(d_lookup(di_l)) * 32'(wi_l)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> ($stable(fi_l) && $stable(di_l) && $stable(wi_l)));

    // R4
    bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((f_lookup(fi_l) == '0) || (d_lookup(di_l) == '0))) |-> !ratio_ok);

endmodule

// File: tb/test_iso_rate_calc.sv
module test_iso_rate_calc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  fi_idx, di_idx;
    logic [7:0]  wi;
    logic [9:0]  ratio;
    logic        ratio_ok;
    logic [23:0] wtime;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    iso_rate_calc i_iso_rate_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fi_idx(fi_idx), .di_idx(di_idx), .wi(wi),
        .ratio(ratio), .ratio_ok(ratio_ok), .wtime(wtime), .done(done)
    );

    typedef struct packed {
        logic [3:0]  fi;
        logic [3:0]  di;
        logic [7:0]  wi;
        logic [9:0]  er;
        logic        eok;
        logic [23:0] ewt;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  4'd1,  8'd10,  10'd372, 1'b1, 24'd9600},
        '{4'd1,  4'd2,  8'd255, 10'd186, 1'b1, 24'd489600},
        '{4'd6,  4'd5,  8'd1,   10'd116, 1'b1, 24'd15360},
        '{4'd9,  4'd10, 8'd3,   10'd116, 1'b0, 24'd5760},
        '{4'd2,  4'd10, 8'd0,   10'd116, 1'b0, 24'd0},
        '{4'd1,  4'd10, 8'd7,   10'd744, 1'b1, 24'd13440},
        '{4'd0,  4'd1,  8'd5,   10'd744, 1'b0, 24'd4800},
        '{4'd3,  4'd6,  8'd5,   10'd744, 1'b0, 24'd0},
        '{4'd13, 4'd3,  8'd2,   10'd512, 1'b1, 24'd7680},
        '{4'd4,  4'd4,  8'd20,  10'd139, 1'b1, 24'd153600},
        '{4'd7,  4'd1,  8'd1,   10'd139, 1'b0, 24'd960},
        '{4'd1,  4'd15, 8'd255, 10'd139, 1'b0, 24'd15667200},
        '{4'd12, 4'd2,  8'd9,   10'd768, 1'b1, 24'd17280},
        '{4'd1,  4'd8,  8'd1,   10'd768, 1'b0, 24'd0},
        '{4'd1,  4'd11, 8'd1,   10'd768, 1'b0, 24'd3840}
    };

    function automatic bit zero_entry(input logic [3:0] f, input logic [3:0] d);
        bit fz = (f == 0) || (f == 7) || (f == 8) || (f >= 14);
        bit dz = (d == 0) || ((d >= 6) && (d <= 9));
        return fz || dz;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                break;
            end
        end
        if (!seen) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7 done never rose: actual 0 expected 1");
        end
    endtask

    task automatic issue(input logic [3:0] f, input logic [3:0] d, input logic [7:0] w);
        @(negedge clk);
        fi_idx = f; di_idx = d; wi = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; fi_idx = '0; di_idx = '0; wi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "ratio",    32'(ratio),    32'd372);
        check("R1", "ratio_ok", 32'(ratio_ok), 32'd1);
        check("R1", "wtime",    32'(wtime),    32'd9600);
        check("R1", "done",     32'(done),     32'd0);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VECS[i].eok)                           tag = (VECS[i].di < 8) ? "R2" : "R3";
            else if (zero_entry(VECS[i].fi, VECS[i].di)) tag = "R4";
            else                                       tag = "R5";
            issue(VECS[i].fi, VECS[i].di, VECS[i].wi);
            wait_done();
            check(tag,  "ratio",    32'(ratio),    32'(VECS[i].er));
            check(tag,  "ratio_ok", 32'(ratio_ok), 32'(VECS[i].eok));
            check("R6", "wtime",    32'(wtime),    32'(VECS[i].ewt));
            @(negedge clk);
            check("R7", "done width", 32'(done), 32'd0);
        end

        // R7 outputs hold while idle
        repeat (6) @(negedge clk);
        check("R7", "held ratio", 32'(ratio), 32'd768);
        check("R7", "held wtime", 32'(wtime), 32'd3840);
        check("R7", "idle done",  32'(done),  32'd0);

        // R8 start while busy is ignored
        issue(4'd2, 4'd1, 8'd1);
        repeat (3) @(negedge clk);
        fi_idx = 4'd6; di_idx = 4'd1; wi = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R8", "ratio", 32'(ratio), 32'd558);
        check("R8", "wtime", 32'(wtime), 32'd960);
        begin
            int extra = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R8", "stray done", 32'(extra), 32'd0);
        end

        // R9 start in the done cycle
        issue(4'd1, 4'd2, 8'd1);
        wait_done();
        check("R9", "first ratio", 32'(ratio), 32'd186);
        check("R9", "first wtime", 32'(wtime), 32'd1920);
        fi_idx = 4'd9; di_idx = 4'd1; wi = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "done dropped", 32'(done), 32'd0);
        wait_done();
        check("R9", "second ratio", 32'(ratio),    32'd512);
        check("R9", "second ok",    32'(ratio_ok), 32'd1);
        check("R9", "second wtime", 32'(wtime),    32'd2880);

        // R1 reset mid-stream restores defaults
        issue(4'd13, 4'd3, 8'd4);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "re-reset ratio", 32'(ratio), 32'd372);
        check("R1", "re-reset wtime", 32'(wtime), 32'd9600);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule